// File: doc/BRIEF.md
# Tape Formatter Register Interface

This block is the register file and command launcher of a magnetic tape formatter. It sits on a 16-bit register bus with 4-bit offsets. It keeps the command, frame count, error, maintenance and tape-control registers. The formatter status, attention summary, drive type, check character and serial number words are built from stored flags and from the live state of the selected drive.

Software sets the go bit together with a function code in the command register. In that same cycle the block checks the preconditions for the function. It then either issues a start request to a drive sequencer, or it records an error, drops go and raises attention.

While go is set, most writes are refused. Motion and transfer functions keep go set until the sequencer reports completion. Every bus access gets a response one cycle later: read data, or a non-existent-register flag.

Top module: `tfmt_regif`

## Requirements
- R1: After reset the command word reads 0x0800 (bit 11, drive available, always set; function in bits 5:1; go in bit 0). Error, tape control, frame count and attention read zero. With the drive offline and idle, formatter status reads 0x0180 (present bit 8, ready bit 7).
- R2: While go is set, a write to the command (offset 0), frame count (5) or tape control (9) register, or to a read-only register (1, 2, 6, 7, 8), leaves that register unchanged. It also sets error bit 2 (refused) and raises attention.
- R3: Writing the frame count sets tape-control bit 14. Writing tape control stores only bits 12 and 10:0 of the data, keeps bit 14 and sets bit 13.
- R4: A go write whose function is not 4 (formatter clear) sets error bit 0, leaves go clear, raises attention and issues no start when either of these holds: the error register is nonzero, or the selected drive is busy.
- R5: Formatter clear is accepted even with errors pending. It zeroes the error register, clears tape-control bit 14 and the slave-change status bit (6), and leaves go clear.
- R6: Read-in preset (function 8) loads tape control with 0x03C0 (density 3 in bits 10:8, format 12 in bits 7:4). It issues a start to drive 0 with function 8 and leaves go clear.
- R7: These are rejected with error bit 11: space forward (12) or space reverse (13) while tape-control bit 14 is clear; write (24) while bit 14 is clear; and write at density 3 when the frame count is above 0xFFF5.
- R8: A write mark (11), erase (10) or data function (20 and above) whose format field (tape control bits 7:4) is neither 12 nor 13 sets error bit 4.
- R9: The attention summary (offset 4) reads attention in bit 0. Writing 1 to bit 0 clears attention, and writing 0 leaves it.
- R10: Drive type (offset 6) reads bits 15 and 14, plus bit 5 when the newer formatter variant is configured. It adds bit 3 for an absent drive, or bit 10 plus a type code (9, 10, 12) for a present one. Serial number (offset 8) reads 0x20 plus drive number plus 1 for a present drive, and 0 otherwise.
- R11: Formatter status bit 7 (ready) is set only while the selected drive is idle and go is clear. Bit 14 is set exactly when the error register is nonzero.
- R12: An access to offsets 10 to 15 returns the non-existent flag in the following cycle and changes no state.
- R13: An accepted function other than nop, formatter clear and read-in preset pulses the start output one cycle after the go write, carrying the function and the selected drive. Rewind (3) and unload (1) clear go at once. Other functions hold go until completion, and completion raises attention for functions below 20. A motion or transfer on an offline drive sets error bit 14.
- R14: Function codes outside the set 0, 1, 3, 4, 8, 10, 11, 12, 13, 20, 23, 24, 28, 31 set error bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 16 | Read data |
| rsp_nxr | output | 1 | Offset does not exist |
| sel_drive | output | 3 | Selected drive (tape control bits 2:0) |
| drv_present | input | 1 | Selected drive exists |
| drv_type | input | 2 | Selected drive model (0, 1, 2) |
| drv_online | input | 1 | Medium loaded on selected drive |
| drv_busy | input | 1 | Selected drive has an operation running |
| drv_pip | input | 1 | Positioning in progress |
| drv_wlock | input | 1 | Medium write locked |
| drv_bot | input | 1 | At beginning of tape |
| drv_eot | input | 1 | Past end of tape |
| drv_pe | input | 1 | Phase-encoded density |
| slave_change | input | 1 | Drive status changed, sets status bit 6 |
| cmd_done | input | 1 | Sequencer finished the running function |
| done_tmk | input | 1 | Tape mark met, valid with cmd_done |
| cmd_start | output | 1 | Start request pulse |
| cmd_func | output | 5 | Function for the start request |
| cmd_drive | output | 3 | Drive for the start request |

## Verification
The assertions assume that cmd_done arrives only while a motion or transfer holds go. They also assume that drive state is stable and known in the cycle after any reset-time access. The bench pulses cmd_done only after a start that left go set, and it changes drive inputs only between accesses, never during one. The assertions also take bus inputs as zero during reset, and the bench holds every request line low until reset is released.

// File: rtl/tfmt_pkg.sv
// Shared constants for the tape formatter register interface.
// Assumes a 16-bit register word and 4-bit register offsets.
package tfmt_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;
    localparam int FUNC_W = 5;

    // Register offsets (decoded by software, so fixed).
    localparam logic [ADDR_W-1:0] OFS_CTL = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_FS  = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_ER  = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_MR  = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_AS  = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_FC  = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_DT  = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_CC  = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_SN  = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_TC  = 4'd9;

    // Function codes.
    localparam logic [FUNC_W-1:0] FN_NOP    = 5'd0;
    localparam logic [FUNC_W-1:0] FN_UNLOAD = 5'd1;
    localparam logic [FUNC_W-1:0] FN_REWIND = 5'd3;
    localparam logic [FUNC_W-1:0] FN_FCLR   = 5'd4;
    localparam logic [FUNC_W-1:0] FN_PRESET = 5'd8;
    localparam logic [FUNC_W-1:0] FN_ERASE  = 5'd10;
    localparam logic [FUNC_W-1:0] FN_WMARK  = 5'd11;
    localparam logic [FUNC_W-1:0] FN_SPCF   = 5'd12;
    localparam logic [FUNC_W-1:0] FN_SPCR   = 5'd13;
    localparam logic [FUNC_W-1:0] FN_WCHKF  = 5'd20;
    localparam logic [FUNC_W-1:0] FN_WCHKR  = 5'd23;
    localparam logic [FUNC_W-1:0] FN_WRITE  = 5'd24;
    localparam logic [FUNC_W-1:0] FN_READF  = 5'd28;
    localparam logic [FUNC_W-1:0] FN_READR  = 5'd31;
    localparam logic [FUNC_W-1:0] FN_XFER_BASE = 5'd20;

    // Error register bit positions.
    localparam int EB_BADFN  = 0;
    localparam int EB_REFUSE = 2;
    localparam int EB_FMTSEL = 4;
    localparam int EB_NOEXEC = 11;
    localparam int EB_UNSAFE = 14;

    // Tape control fields.
    localparam logic [REG_W-1:0] TC_WR_MASK = 16'h17FF;
    localparam int TC_ADDRCHG = 13;
    localparam int TC_FCSET   = 14;
    localparam logic [REG_W-1:0] TC_PRESET = 16'h03C0;
    localparam logic [2:0] DEN_NRZ     = 3'd3;
    localparam logic [3:0] FMT_STD     = 4'd12;
    localparam logic [3:0] FMT_DUMP    = 4'd13;
    localparam logic [REG_W-1:0] FC_NRZ_LIMIT = 16'hFFF5;

    // Maintenance register writable bits.
    localparam logic [REG_W-1:0] MR_WR_MASK = 16'hFF9F;

    // Outcome of a go-bit write.
    typedef struct packed {
        logic             start;
        logic             hold_go;
        logic             clr_tmk;
        logic [REG_W-1:0] err_set;
    } verdict_t;
endpackage

// File: rtl/tfmt_cmd_check.sv
// Function validation for a go-bit write: decides whether the function
// starts, keeps go set, or which error bits it raises. Purely combinational;
// assumes drive inputs describe the currently selected drive.
module tfmt_cmd_check
    import tfmt_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    input  logic              err_any,
    input  logic              drv_busy,
    input  logic              drv_online,
    input  logic              drv_wlock,
    input  logic              drv_bot,
    input  logic              drv_eot,
    input  logic              fc_set,
    input  logic [2:0]        density,
    input  logic [3:0]        fmt,
    input  logic [REG_W-1:0]  fc,
    output verdict_t          verdict
);
    logic fmt_ok;
    logic at_bot;
    logic at_eot;

    // Format and position qualifiers shared by several functions.
    always_comb begin
        fmt_ok = (fmt == FMT_STD) || (fmt == FMT_DUMP);
        at_bot = drv_online && drv_bot;
        at_eot = drv_online && drv_eot;
    end

    // Precondition ladder per function code.
    always_comb begin
        logic xfer;
        verdict = '0;
        xfer    = 1'b0;
        if ((func != FN_FCLR) && (err_any || drv_busy)) begin
            verdict.err_set[EB_BADFN] = 1'b1;
        end else begin
            unique case (func)
                FN_NOP, FN_FCLR: ;
                FN_PRESET: verdict.start = 1'b1;
                FN_UNLOAD, FN_REWIND: begin
                    if (!drv_online) verdict.err_set[EB_UNSAFE] = 1'b1;
                    else begin
                        verdict.start   = 1'b1;
                        verdict.clr_tmk = 1'b1;
                    end
                end
                FN_SPCF, FN_SPCR: begin
                    if (!drv_online) verdict.err_set[EB_UNSAFE] = 1'b1;
                    else if (!fc_set || ((func == FN_SPCF) ? at_eot : at_bot))
                        verdict.err_set[EB_NOEXEC] = 1'b1;
                    else begin
                        verdict.start   = 1'b1;
                        verdict.hold_go = 1'b1;
                        verdict.clr_tmk = 1'b1;
                    end
                end
                FN_READR, FN_WCHKR: begin
                    if (at_bot) verdict.err_set[EB_NOEXEC] = 1'b1;
                    else xfer = 1'b1;
                end
                FN_WRITE: begin
                    if (!fc_set || ((density == DEN_NRZ) && (fc > FC_NRZ_LIMIT)))
                        verdict.err_set[EB_NOEXEC] = 1'b1;
                    else if (drv_wlock) verdict.err_set[EB_NOEXEC] = 1'b1;
                    else xfer = 1'b1;
                end
                FN_WMARK, FN_ERASE: begin
                    if (drv_wlock) verdict.err_set[EB_NOEXEC] = 1'b1;
                    else xfer = 1'b1;
                end
                FN_READF, FN_WCHKF: xfer = 1'b1;
                default: verdict.err_set[EB_BADFN] = 1'b1;
            endcase
            if (xfer) begin
                if (!drv_online) verdict.err_set[EB_UNSAFE] = 1'b1;
                else if (!fmt_ok) verdict.err_set[EB_FMTSEL] = 1'b1;
                else begin
                    verdict.start   = 1'b1;
                    verdict.hold_go = 1'b1;
                    verdict.clr_tmk = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tfmt_readback.sv
// Read path: composes the live status, drive type and serial words and
// selects the word for an offset. Flags offsets that do not exist and
// offsets that are read-only. Assumes drive inputs follow the selected drive.
module tfmt_readback
    import tfmt_pkg::*;
#(
    parameter int NUM_DRV   = 8,
    parameter bit NEWER_FMT = 1'b1,
    localparam int SEL_W    = $clog2(NUM_DRV)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              go,
    input  logic [FUNC_W-1:0] func,
    input  logic [REG_W-1:0]  fc,
    input  logic [REG_W-1:0]  er,
    input  logic [REG_W-1:0]  mr,
    input  logic [REG_W-1:0]  tc,
    input  logic              ata,
    input  logic              tmk,
    input  logic              ssc,
    input  logic              drv_present,
    input  logic [1:0]        drv_type,
    input  logic              drv_online,
    input  logic              drv_busy,
    input  logic              drv_pip,
    input  logic              drv_wlock,
    input  logic              drv_bot,
    input  logic              drv_eot,
    input  logic              drv_pe,
    output logic [REG_W-1:0]  rd_word,
    output logic              nxr_hit,
    output logic              ro_hit,
    output logic              err_any
);
    localparam int LAST_OFS = 9;

    logic [REG_W-1:0] fs_word;
    logic [REG_W-1:0] dt_word;
    logic [REG_W-1:0] sn_word;
    logic             variant_bit;
    logic [3:0]       type_code;
    logic [SEL_W-1:0] sel;

    // Formatter-variant flag in the drive type word, chosen at build time.
    generate
        if (NEWER_FMT) begin : g_newer
            assign variant_bit = 1'b1;
        end else begin : g_older
            assign variant_bit = 1'b0;
        end
    endgenerate

    // Drive model to drive-type code.
    always_comb begin
        unique case (drv_type)
            2'd1:    type_code = 4'd10;
            2'd2:    type_code = 4'd12;
            default: type_code = 4'd9;
        endcase
    end

    // Live status, drive type and serial number words.
    always_comb begin
        sel      = tc[SEL_W-1:0];
        err_any  = (er != '0);
        fs_word  = '0;
        fs_word[15] = ata;
        fs_word[14] = err_any;
        fs_word[13] = drv_online && drv_pip;
        fs_word[12] = drv_online;
        fs_word[11] = drv_online && drv_wlock;
        fs_word[10] = drv_online && !drv_busy && drv_eot;
        fs_word[8]  = 1'b1;
        fs_word[7]  = !drv_busy && !go;
        fs_word[6]  = ssc;
        fs_word[5]  = drv_online && drv_pe;
        fs_word[2]  = tmk;
        fs_word[1]  = drv_online && !drv_busy && drv_bot;
        dt_word = 16'hC000;
        dt_word[5] = variant_bit;
        if (drv_present) begin
            dt_word[10]  = 1'b1;
            dt_word[3:0] = type_code;
        end else begin
            dt_word[3] = 1'b1;
        end
        sn_word = drv_present ? (REG_W'(16'h0020) + REG_W'(sel) + REG_W'(1)) : '0;
    end

    // Offset decode for read data and access classes.
    always_comb begin
        nxr_hit = (int'(addr) > LAST_OFS);
        ro_hit  = (addr == OFS_FS) || (addr == OFS_ER) || (addr == OFS_DT) ||
                  (addr == OFS_CC) || (addr == OFS_SN);
        unique case (addr)
            OFS_CTL: rd_word = {4'b0, 1'b1, 5'b0, func, go};
            OFS_FS:  rd_word = fs_word;
            OFS_ER:  rd_word = er;
            OFS_MR:  rd_word = mr;
            OFS_AS:  rd_word = {15'b0, ata};
            OFS_FC:  rd_word = fc;
            OFS_DT:  rd_word = dt_word;
            OFS_CC:  rd_word = '0;
            OFS_SN:  rd_word = sn_word;
            OFS_TC:  rd_word = tc;
            default: rd_word = '0;
        endcase
    end
endmodule

// File: rtl/tfmt_regif.sv
// Top of the tape formatter register interface. Holds the writable
// registers, applies the refused-write rule, runs go-bit writes through
// the function checker and issues start requests. Assumes one access per
// cycle and that cmd_done only follows a start that kept go set.
module tfmt_regif
    import tfmt_pkg::*;
#(
    parameter int NUM_DRV   = 8,
    parameter bit NEWER_FMT = 1'b1,
    localparam int SEL_W    = $clog2(NUM_DRV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic              rsp_valid,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic              rsp_nxr,
    output logic [SEL_W-1:0]  sel_drive,
    input  logic              drv_present,
    input  logic [1:0]        drv_type,
    input  logic              drv_online,
    input  logic              drv_busy,
    input  logic              drv_pip,
    input  logic              drv_wlock,
    input  logic              drv_bot,
    input  logic              drv_eot,
    input  logic              drv_pe,
    input  logic              slave_change,
    input  logic              cmd_done,
    input  logic              done_tmk,
    output logic              cmd_start,
    output logic [FUNC_W-1:0] cmd_func,
    output logic [SEL_W-1:0]  cmd_drive
);
    logic              go_q, go_n;
    logic [FUNC_W-1:0] func_q, func_n;
    logic [REG_W-1:0]  fc_q, fc_n;
    logic [REG_W-1:0]  er_q, er_n;
    logic [REG_W-1:0]  mr_q, mr_n;
    logic [REG_W-1:0]  tc_q, tc_n;
    logic              ata_q, ata_n;
    logic              tmk_q, tmk_n;
    logic              ssc_q, ssc_n;
    logic              start_n;
    logic [FUNC_W-1:0] sfunc_n;
    logic [SEL_W-1:0]  sdrv_n;

    logic [REG_W-1:0]  rd_word;
    logic              nxr_hit;
    logic              ro_hit;
    logic              err_any;
    verdict_t          verdict;
    logic [FUNC_W-1:0] wr_func;

    assign wr_func   = bus_wdata[FUNC_W:1];
    assign sel_drive = tc_q[SEL_W-1:0];

    tfmt_readback #(.NUM_DRV(NUM_DRV), .NEWER_FMT(NEWER_FMT)) u_rd (
        .addr(bus_addr), .go(go_q), .func(func_q), .fc(fc_q), .er(er_q),
        .mr(mr_q), .tc(tc_q), .ata(ata_q), .tmk(tmk_q), .ssc(ssc_q),
        .drv_present(drv_present), .drv_type(drv_type),
        .drv_online(drv_online), .drv_busy(drv_busy), .drv_pip(drv_pip),
        .drv_wlock(drv_wlock), .drv_bot(drv_bot), .drv_eot(drv_eot),
        .drv_pe(drv_pe), .rd_word(rd_word), .nxr_hit(nxr_hit),
        .ro_hit(ro_hit), .err_any(err_any)
    );

    tfmt_cmd_check u_chk_fn (
        .func(wr_func), .err_any(err_any), .drv_busy(drv_busy),
        .drv_online(drv_online), .drv_wlock(drv_wlock), .drv_bot(drv_bot),
        .drv_eot(drv_eot), .fc_set(tc_q[TC_FCSET]), .density(tc_q[10:8]),
        .fmt(tc_q[7:4]), .fc(fc_q), .verdict(verdict)
    );

    // Next-state: completion first, then the bus access, which wins on overlap.
    always_comb begin
        logic refused;
        go_n    = go_q;
        func_n  = func_q;
        fc_n    = fc_q;
        er_n    = er_q;
        mr_n    = mr_q;
        tc_n    = tc_q;
        ata_n   = ata_q;
        tmk_n   = tmk_q;
        ssc_n   = ssc_q || slave_change;
        start_n = 1'b0;
        sfunc_n = wr_func;
        sdrv_n  = tc_q[SEL_W-1:0];
        refused = 1'b0;

        if (cmd_done && go_q) begin
            go_n = 1'b0;
            if (func_q < FN_XFER_BASE) ata_n = 1'b1;
            if (done_tmk) tmk_n = 1'b1;
        end

        if (bus_valid && bus_write && !nxr_hit) begin
            refused = go_q && (ro_hit || (bus_addr == OFS_CTL) ||
                               (bus_addr == OFS_FC) || (bus_addr == OFS_TC));
            if (refused) begin
                er_n[EB_REFUSE] = 1'b1;
                ata_n = 1'b1;
            end else begin
                unique case (bus_addr)
                    OFS_CTL: begin
                        func_n = wr_func;
                        if (bus_wdata[0]) begin
                            if (verdict.err_set != '0) begin
                                er_n  = er_q | verdict.err_set;
                                ata_n = 1'b1;
                                go_n  = 1'b0;
                            end else begin
                                ata_n = 1'b0;
                                tc_n[TC_ADDRCHG] = 1'b0;
                                go_n    = verdict.hold_go;
                                start_n = verdict.start;
                                if (verdict.clr_tmk) tmk_n = 1'b0;
                                if (wr_func == FN_FCLR) begin
                                    er_n  = '0;
                                    tc_n[TC_FCSET] = 1'b0;
                                    ssc_n = 1'b0;
                                end
                                if (wr_func == FN_PRESET) begin
                                    tc_n   = TC_PRESET;
                                    sdrv_n = '0;
                                    tmk_n  = 1'b0;
                                end
                            end
                        end
                    end
                    OFS_FC: begin
                        fc_n = bus_wdata;
                        tc_n[TC_FCSET] = 1'b1;
                    end
                    OFS_AS: if (bus_wdata[0]) ata_n = 1'b0;
                    OFS_MR: mr_n = (mr_q & ~MR_WR_MASK) | (bus_wdata & MR_WR_MASK);
                    OFS_TC: begin
                        tc_n = (tc_q & ~TC_WR_MASK) | (bus_wdata & TC_WR_MASK);
                        tc_n[TC_ADDRCHG] = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // State and response registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q      <= 1'b0;
            func_q    <= '0;
            fc_q      <= '0;
            er_q      <= '0;
            mr_q      <= '0;
            tc_q      <= '0;
            ata_q     <= 1'b0;
            tmk_q     <= 1'b0;
            ssc_q     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_nxr   <= 1'b0;
            cmd_start <= 1'b0;
            cmd_func  <= '0;
            cmd_drive <= '0;
        end else begin
            go_q      <= go_n;
            func_q    <= func_n;
            fc_q      <= fc_n;
            er_q      <= er_n;
            mr_q      <= mr_n;
            tc_q      <= tc_n;
            ata_q     <= ata_n;
            tmk_q     <= tmk_n;
            ssc_q     <= ssc_n;
            rsp_valid <= bus_valid;
            rsp_rdata <= bus_valid ? rd_word : '0;
            rsp_nxr   <= bus_valid && nxr_hit;
            cmd_start <= start_n;
            if (start_n) begin
                cmd_func  <= sfunc_n;
                cmd_drive <= sdrv_n;
            end
        end
    end
endmodule

// File: rtl/tfmt_regif_chk.sv
// Assertion checker for tfmt_regif, attached by bind below.
// Assumes bus inputs are low during reset.
module tfmt_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [3:0]  bus_addr,
    input logic [5:0]  bus_wlow,
    input logic        drv_busy,
    input logic        cmd_start,
    input logic        rsp_valid,
    input logic        rsp_nxr,
    input logic        rsp_ready_bit,
    input logic        go_q,
    input logic [15:0] er_q,
    input logic [15:0] tc_q,
    input logic [15:0] fc_q
);
    p_refuse_tc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 4'd9 && go_q)
        |=> ($stable(tc_q) && er_q[2]));

    p_refuse_fc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 4'd5 && go_q)
        |=> ($stable(fc_q) && er_q[2]));

    p_busy_badfn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 4'd0 && !go_q && bus_wlow[0] &&
         bus_wlow[5:1] != 5'd4 && drv_busy)
        |=> (er_q[0] && !go_q && !cmd_start));

    p_fclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 4'd0 && !go_q && bus_wlow[0] &&
         bus_wlow[5:1] == 5'd4)
        |=> (er_q == 16'h0 && !tc_q[14] && !go_q));

    p_nxr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr > 4'd9) |=> (rsp_valid && rsp_nxr));

    p_start_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(bus_valid && bus_write && bus_addr == 4'd0 && bus_wlow[0]));

    p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(bus_valid && !bus_write && bus_addr == 4'd1 && drv_busy))
        |-> !rsp_ready_bit);
endmodule

bind tfmt_regif tfmt_regif_chk u_regif_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wlow(bus_wdata[5:0]), .drv_busy(drv_busy),
    .cmd_start(cmd_start), .rsp_valid(rsp_valid), .rsp_nxr(rsp_nxr),
    .rsp_ready_bit(rsp_rdata[7]), .go_q(go_q), .er_q(er_q), .tc_q(tc_q),
    .fc_q(fc_q)
);

// File: tb/sim_tfmt_regif.sv
module sim_tfmt_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        rsp_valid, rsp_nxr;
    logic [15:0] rsp_rdata;
    logic [2:0]  sel_drive, cmd_drive;
    logic        drv_present = 0, drv_online = 0, drv_busy = 0, drv_pip = 0;
    logic        drv_wlock = 0, drv_bot = 0, drv_eot = 0, drv_pe = 0;
    logic [1:0]  drv_type = 0;
    logic        slave_change = 0, cmd_done = 0, done_tmk = 0;
    logic        cmd_start;
    logic [4:0]  cmd_func;

    int total = 0, bad = 0;
    logic [15:0] rd;
    logic        nx, st;

    always #2 clk = ~clk;

    tfmt_regif u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_nxr(rsp_nxr), .sel_drive(sel_drive),
        .drv_present(drv_present), .drv_type(drv_type), .drv_online(drv_online),
        .drv_busy(drv_busy), .drv_pip(drv_pip), .drv_wlock(drv_wlock),
        .drv_bot(drv_bot), .drv_eot(drv_eot), .drv_pe(drv_pe),
        .slave_change(slave_change), .cmd_done(cmd_done), .done_tmk(done_tmk),
        .cmd_start(cmd_start), .cmd_func(cmd_func), .cmd_drive(cmd_drive)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [3:0] a, input logic [15:0] d);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rd = rsp_rdata; nx = rsp_nxr; st = cmd_start;
    endtask

    task automatic rdreg(input logic [3:0] a);
        acc(1'b0, a, 16'h0);
    endtask

    task automatic done_pulse();
        cmd_done = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_done = 1'b0;
    endtask

    task automatic prep(input logic [15:0] fc, input logic [15:0] tc);
        acc(1'b1, 4'd0, 16'h0009);
        acc(1'b1, 4'd5, fc);
        acc(1'b1, 4'd9, tc);
    endtask

    function automatic bit legal_fn(input int f);
        return f == 0 || f == 1 || f == 3 || f == 4 || f == 8 || f == 10 || f == 11 ||
               f == 12 || f == 13 || f == 20 || f == 23 || f == 24 || f == 28 || f == 31;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rdreg(4'd0); check("R1 ctl", rd, 16'h0800);
        rdreg(4'd1); check("R1 fs", rd, 16'h0180);
        rdreg(4'd2); check("R1 er", rd, 16'h0000);
        rdreg(4'd9); check("R1 tc", rd, 16'h0000);
        rdreg(4'd4); check("R1 as", rd, 16'h0000);

        // R12 offset sweep
        for (int a = 0; a < 16; a++) begin
            rdreg(4'(a)); check("R12 nxr", {15'b0, nx}, {15'b0, (a > 9)});
        end
        acc(1'b1, 4'd12, 16'hFFFF);
        check("R12 nxr write", {15'b0, nx}, 16'h1);
        rdreg(4'd2); check("R12 er unchanged", rd, 16'h0000);
        rdreg(4'd3); check("R12 mr unchanged", rd, 16'h0000);

        // R10 drive type and serial number
        drv_online = 1; drv_present = 1;
        for (int t = 0; t < 3; t++) begin
            drv_type = 2'(t);
            rdreg(4'd6);
            check("R10 dt present", rd, 16'hC420 | ((t == 0) ? 16'd9 : (t == 1) ? 16'd10 : 16'd12));
        end
        drv_type = 0;
        drv_present = 0;
        rdreg(4'd6); check("R10 dt absent", rd, 16'hC028);
        rdreg(4'd8); check("R10 sn absent", rd, 16'h0000);
        drv_present = 1;
        acc(1'b1, 4'd9, 16'h0005);
        rdreg(4'd8); check("R10 sn drive5", rd, 16'h0026);

        // R3 frame count and tape control write rules
        acc(1'b1, 4'd5, 16'h1234);
        rdreg(4'd9); check("R3 fcs set", rd, 16'h6005);
        acc(1'b1, 4'd9, 16'hFFFF);
        rdreg(4'd9); check("R3 tc mask", rd, 16'h77FF);

        // R13 R14 function sweep on a ready drive
        for (int f = 0; f < 32; f++) begin
            bit keep, strt;
            prep(16'h0000, 16'h04C0);
            acc(1'b1, 4'd0, 16'((f << 1) | 1));
            strt = legal_fn(f) && !(f == 0 || f == 4);
            keep = legal_fn(f) && (f >= 10) && (f != 8);
            check("R13 start pulse", {15'b0, st}, {15'b0, strt});
            if (strt) check("R13 start func", {11'b0, cmd_func}, 16'(f));
            rdreg(4'd2); check("R14 function error", rd, legal_fn(f) ? 16'h0 : 16'h0001);
            rdreg(4'd0); check("R13 go state", rd, 16'h0800 | 16'(f << 1) | {15'b0, keep});
            if (keep) begin
                done_pulse();
                rdreg(4'd4); check("R13 done attention", rd, (f < 20) ? 16'h1 : 16'h0);
            end
        end

        // R2 refused writes while go is set
        prep(16'h0003, 16'h04C0);
        acc(1'b1, 4'd0, 16'h0019);
        acc(1'b1, 4'd9, 16'h0000);
        rdreg(4'd9); check("R2 tc kept", rd, 16'h44C0);
        acc(1'b1, 4'd5, 16'h7777);
        rdreg(4'd5); check("R2 fc kept", rd, 16'h0003);
        acc(1'b1, 4'd0, 16'h0000);
        rdreg(4'd0); check("R2 ctl kept", rd, 16'h0819);
        rdreg(4'd2); check("R2 refuse bit", rd, 16'h0004);
        rdreg(4'd4); check("R2 attention", rd, 16'h0001);
        done_pulse();
        rdreg(4'd0); check("R13 go cleared on done", rd, 16'h0818);

        // R4 errors pending and busy drive
        acc(1'b1, 4'd0, 16'h0039);
        rdreg(4'd2); check("R4 err pending", rd, 16'h0005);
        rdreg(4'd0); check("R4 go clear", rd, 16'h0838);
        rdreg(4'd1); check("R11 err summary", rd & 16'h4000, 16'h4000);
        acc(1'b1, 4'd0, 16'h0009);
        rdreg(4'd2); check("R5 er zero", rd, 16'h0000);
        rdreg(4'd9); check("R5 fcs clear", rd & 16'h4000, 16'h0000);
        rdreg(4'd1); check("R11 err summary clear", rd & 16'h4000, 16'h0000);
        drv_busy = 1;
        rdreg(4'd1); check("R11 ready busy", rd & 16'h0080, 16'h0000);
        acc(1'b1, 4'd0, 16'h0039);
        check("R4 no start", {15'b0, st}, 16'h0);
        rdreg(4'd2); check("R4 busy error", rd, 16'h0001);
        drv_busy = 0;
        rdreg(4'd1); check("R11 ready idle", rd & 16'h0080, 16'h0080);

        // R5 slave change cleared by formatter clear
        slave_change = 1; @(negedge clk); slave_change = 0;
        rdreg(4'd1); check("R5 ssc set", rd & 16'h0040, 16'h0040);
        acc(1'b1, 4'd0, 16'h0009);
        rdreg(4'd1); check("R5 ssc cleared", rd & 16'h0040, 16'h0000);

        // R7 frame-count gating and density limit
        acc(1'b1, 4'd9, 16'h04C0);
        acc(1'b1, 4'd0, 16'h0019);
        rdreg(4'd2); check("R7 space without fc", rd, 16'h0800);
        acc(1'b1, 4'd0, 16'h0009);
        acc(1'b1, 4'd9, 16'h04C0);
        acc(1'b1, 4'd0, 16'h0031);
        rdreg(4'd2); check("R7 write without fc", rd, 16'h0800);
        prep(16'hFFF6, 16'h03C0);
        acc(1'b1, 4'd0, 16'h0031);
        rdreg(4'd2); check("R7 short nrz write", rd, 16'h0800);
        prep(16'hFFF5, 16'h03C0);
        acc(1'b1, 4'd0, 16'h0031);
        check("R7 limit write starts", {15'b0, st}, 16'h1);
        rdreg(4'd2); check("R7 limit write ok", rd, 16'h0000);
        done_pulse();

        // R8 format select
        prep(16'h0000, 16'h0400);
        acc(1'b1, 4'd0, 16'h0039);
        rdreg(4'd2); check("R8 bad format", rd, 16'h0010);
        prep(16'h0000, 16'h04D0);
        acc(1'b1, 4'd0, 16'h0039);
        check("R8 dump format starts", {15'b0, st}, 16'h1);
        done_pulse();

        // R13 offline drive
        drv_online = 0;
        prep(16'h0000, 16'h04C0);
        acc(1'b1, 4'd0, 16'h0007);
        rdreg(4'd2); check("R13 offline unsafe", rd, 16'h4000);
        drv_online = 1;

        // R9 attention summary
        rdreg(4'd4); check("R9 attention read", rd, 16'h0001);
        acc(1'b1, 4'd4, 16'h0000);
        rdreg(4'd4); check("R9 write zero keeps", rd, 16'h0001);
        acc(1'b1, 4'd4, 16'h0001);
        rdreg(4'd4); check("R9 write one clears", rd, 16'h0000);

        // R6 read-in preset
        prep(16'h0000, 16'h04C5);
        acc(1'b1, 4'd0, 16'h0011);
        check("R6 start", {15'b0, st}, 16'h1);
        check("R6 drive 0", {13'b0, cmd_drive}, 16'h0);
        rdreg(4'd9); check("R6 tc preset", rd, 16'h03C0);
        rdreg(4'd0); check("R6 go clear", rd, 16'h0810);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule